// File: doc/BRIEF.md
# Four-Port Pin Controller with Open-Drain and Pull-Up Control

This block controls thirty-two general-purpose pins arranged as four ports of eight bits. A processor programs it over a small register bus: an address, a write strobe with write data, and a read strobe with a read-kind select and registered read data. Each port has four eight-bit registers: an output latch, a direction mask, a pull-up mask and a drive-mode mask. From these the block derives, for every pin, the value to drive, an output enable and a pull-up request for an external pad.

Each pin can drive in push-pull or in open-drain fashion. A pin in open-drain mode pulls low only when its latch bit is 0 and releases the line when the bit is 1. Reads of a data address return one of two sources. With the pin-select input low, the read returns the latch. With it high, the read returns the pin level, which passes through a two-stage synchronizer first.

Top module: `pio_ctrl`

## Requirements
- R1: A write with `wr_en` high to data address 0xC0+p (p = 0..3) loads `wr_data` into the latch of port p at that clock edge, and a register read (`rd_pin` = 0) of the same address returns it.
- R2: After reset all four registers of every port are 0, so `pad_oe`, `pad_out` and `pad_pu` are all 0 and every pin is an input.
- R3: Direction registers sit at 0xC8+p; a bit of 1 makes the pin an output and 0 an input, so writing 0x55 to 0xC8 enables the drivers of even pins 0,2,4,6 of port 0 only.
- R4: For a push-pull pin (drive-mode bit 0), `pad_oe` equals its direction bit and `pad_out` equals its latch bit.
- R5: Drive-mode registers sit at 0xD8+p; for an open-drain pin (bit 1), `pad_out` is 0 and `pad_oe` is its direction bit AND NOT its latch bit.
- R6: Pull-up registers sit at 0xD0+p; `pad_pu` of a pin is its pull-up bit AND NOT its `pad_oe`, so the pull-up acts on inputs and on released open-drain pins.
- R7: A read with `rd_pin` = 1 of a data address returns the `pin_in` byte of that port as it stood two clock edges before the edge that captures the read; a change applied one or two edges earlier is not yet seen.
- R8: A read from any address outside the sixteen mapped ones returns 0x00, and a write there changes no register and no pad output.
- R9: `rd_data` is loaded at the clock edge where `rd_en` is high and holds its value at every other edge.
- R10: Reads of direction, pull-up and drive-mode addresses return the register contents whatever the state of `rd_pin`.
- R11: Pin numbering is linear: pin 8*p+b of the flat pad and `pin_in` buses is bit b of port p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_pin | input | 1 | 1 selects the pin level on data-address reads |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 32 | Pin levels from the pads |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Output enable of each pad |
| pad_pu | output | 32 | Pull-up request of each pad |

## Verification
Register writes take effect at the edge carrying the strobe, and the pad outputs are combinational from the registers, so the bench compares all three pad buses half a cycle after each write. Read data is due at the edge that samples `rd_en`, and the bench reads it at the next falling edge. Pin reads carry two further edges of synchronizer latency: the bench applies a new pin pattern and then idles three cycles before any random pin read, and a directed sequence reads at the first, second and third edges after a change to confirm that the old value is returned twice and the new value on the third.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int ADDR_W      = 8;
    localparam int KIND_STRIDE = 8;
    localparam int NUM_KINDS   = 4;
    localparam int MAP_SPAN    = NUM_KINDS * KIND_STRIDE;

    typedef enum logic [1:0] {
        K_LATCH = 2'd0,
        K_DIR   = 2'd1,
        K_PULL  = 2'd2,
        K_MODE  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [2:0] port;
    } reg_sel_t;

    function automatic reg_sel_t map_address(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] base,
                                             input int nports);
        reg_sel_t          s;
        logic [ADDR_W-1:0] off;
        off    = a - base;
        s.kind = reg_kind_e'(off[4:3]);
        s.port = off[2:0];
        s.hit  = (a >= base) && (int'(off) < MAP_SPAN) && (int'(off[2:0]) < nports);
        return s;
    endfunction

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int                NUM_PORTS = 4,
    parameter logic [ADDR_W-1:0] BASE      = 8'hC0
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);
    always_comb begin
        sel = map_address(addr, BASE, NUM_PORTS);
    end
endmodule

// File: rtl/pio_port_bank.sv
module pio_port_bank
    import pio_pkg::*;
#(
    parameter int         PORT_W   = 8,
    parameter logic [2:0] PORT_IDX = 3'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_t          sel,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] latch_q,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] pull_q,
    output logic [PORT_W-1:0] mode_q
);
    logic mine;
    assign mine = wr_en && sel.hit && (sel.port == PORT_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
            mode_q  <= '0;
        end else if (mine) begin
            unique case (sel.kind)
                K_LATCH: latch_q <= wr_data;
                K_DIR:   dir_q   <= wr_data;
                K_PULL:  pull_q  <= wr_data;
                K_MODE:  mode_q  <= wr_data;
            endcase
        end
    end
endmodule

// File: rtl/pio_pad_drive.sv
module pio_pad_drive #(
    parameter int PORT_W = 8
) (
    input  logic [PORT_W-1:0] latch_q,
    input  logic [PORT_W-1:0] dir_q,
    input  logic [PORT_W-1:0] pull_q,
    input  logic [PORT_W-1:0] mode_q,
    output logic [PORT_W-1:0] drv_val,
    output logic [PORT_W-1:0] drv_en,
    output logic [PORT_W-1:0] pu_en
);
    logic [PORT_W-1:0] en_w;

    for (genvar b = 0; b < PORT_W; b++) begin : g_bit
        always_comb begin
            if (mode_q[b]) begin
                en_w[b]    = dir_q[b] & ~latch_q[b];
                drv_val[b] = 1'b0;
            end else begin
                en_w[b]    = dir_q[b];
                drv_val[b] = latch_q[b];
            end
        end
    end

    assign drv_en = en_w;
    assign pu_en  = pull_q & ~en_w;
endmodule

// File: rtl/pio_pin_sync.sv
module pio_pin_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] st;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) st[0] <= '0;
                else     st[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) st[s] <= '0;
                else     st[s] <= st[s-1];
            end
        end
    end

    assign dout = st[STAGES-1];
endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
    import pio_pkg::*;
#(
    parameter int                NUM_PORTS   = 4,
    parameter int                PORT_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] BASE        = 8'hC0
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [PORT_W-1:0]           wr_data,
    input  logic                        rd_en,
    input  logic                        rd_pin,
    output logic [PORT_W-1:0]           rd_data,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pad_pu
);
    localparam int PINS = NUM_PORTS * PORT_W;

    reg_sel_t                           sel;
    logic [NUM_PORTS-1:0][PORT_W-1:0]   latch_a, dir_a, pull_a, mode_a;
    logic [PINS-1:0]                    pins_sync;
    logic [PINS-1:0]                    latch_flat, mode_flat;
    logic [PORT_W-1:0]                  rd_next;

    pio_decode #(.NUM_PORTS(NUM_PORTS), .BASE(BASE)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pio_port_bank #(.PORT_W(PORT_W), .PORT_IDX(3'(p))) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .sel     (sel),
            .wr_data (wr_data),
            .latch_q (latch_a[p]),
            .dir_q   (dir_a[p]),
            .pull_q  (pull_a[p]),
            .mode_q  (mode_a[p])
        );

        pio_pad_drive #(.PORT_W(PORT_W)) u_drive (
            .latch_q (latch_a[p]),
            .dir_q   (dir_a[p]),
            .pull_q  (pull_a[p]),
            .mode_q  (mode_a[p]),
            .drv_val (pad_out[p*PORT_W +: PORT_W]),
            .drv_en  (pad_oe[p*PORT_W +: PORT_W]),
            .pu_en   (pad_pu[p*PORT_W +: PORT_W])
        );

        assign latch_flat[p*PORT_W +: PORT_W] = latch_a[p];
        assign mode_flat[p*PORT_W +: PORT_W]  = mode_a[p];
    end

    pio_pin_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pins_sync)
    );

    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (sel.hit && sel.port == 3'(p)) begin
                unique case (sel.kind)
                    K_LATCH: rd_next = rd_pin ? pins_sync[p*PORT_W +: PORT_W] : latch_a[p];
                    K_DIR:   rd_next = dir_a[p];
                    K_PULL:  rd_next = pull_a[p];
                    K_MODE:  rd_next = mode_a[p];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk #(
    parameter int         NUM_PORTS = 4,
    parameter int         PORT_W    = 8,
    parameter logic [7:0] BASE      = 8'hC0
) (
    input logic                        clk,
    input logic                        rst,
    input logic [7:0]                  addr,
    input logic                        wr_en,
    input logic [PORT_W-1:0]           wr_data,
    input logic                        rd_en,
    input logic [PORT_W-1:0]           rd_data,
    input logic [NUM_PORTS*PORT_W-1:0] pad_out,
    input logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    input logic [NUM_PORTS*PORT_W-1:0] pad_pu,
    input logic [NUM_PORTS*PORT_W-1:0] mode_flat,
    input logic [NUM_PORTS*PORT_W-1:0] latch_flat
);
    logic in_map;
    assign in_map = (int'(addr) >= int'(BASE)) && (int'(addr) < int'(BASE) + 32)
                    && (int'(addr[2:0]) < NUM_PORTS);

    p_quiet_after_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0));

    p_latch_load_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == BASE) |=> (latch_flat[PORT_W-1:0] == $past(wr_data)));

    p_od_never_high_r5: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_out & mode_flat) == '0);

    p_pull_only_undriven_r6: assert property (@(posedge clk) disable iff (rst)
        (pad_pu & pad_oe) == '0);

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_map) |=> (rd_data == '0));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
endmodule

bind pio_ctrl pio_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .BASE(BASE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .mode_flat  (mode_flat),
    .latch_flat (latch_flat)
);

// File: tb/sim_pio_ctrl.sv
module sim_pio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic        rd_pin = 1'b0;
    logic [7:0]  rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pad_out, pad_oe, pad_pu;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [7:0]  m_latch [4];
    logic [7:0]  m_dir   [4];
    logic [7:0]  m_pull  [4];
    logic [7:0]  m_mode  [4];
    logic [31:0] m_pins;

    always #2 clk = ~clk;

    pio_ctrl u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_pin(rd_pin), .rd_data(rd_data), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    function automatic bit is_mapped(input logic [7:0] a);
        return (a >= 8'hC0) && (a < 8'hE0) && (a[2:0] < 3'd4);
    endfunction

    function automatic logic [31:0] f_oe();
        logic [31:0] v = '0;
        for (int p = 0; p < 4; p++)
            for (int b = 0; b < 8; b++)
                v[p*8+b] = m_dir[p][b] & (m_mode[p][b] ? ~m_latch[p][b] : 1'b1);
        return v;
    endfunction

    function automatic logic [31:0] f_out();
        logic [31:0] v = '0;
        for (int p = 0; p < 4; p++)
            for (int b = 0; b < 8; b++)
                v[p*8+b] = m_mode[p][b] ? 1'b0 : m_latch[p][b];
        return v;
    endfunction

    function automatic logic [31:0] f_pu();
        logic [31:0] oe = f_oe();
        logic [31:0] v  = '0;
        for (int p = 0; p < 4; p++)
            for (int b = 0; b < 8; b++)
                v[p*8+b] = m_pull[p][b] & ~oe[p*8+b];
        return v;
    endfunction

    function automatic logic [7:0] f_read(input logic [7:0] a, input logic ps);
        int p;
        if (!is_mapped(a)) return 8'h00;
        p = int'(a[2:0]);
        case (a[4:3])
            2'd0:    return ps ? m_pins[p*8 +: 8] : m_latch[p];
            2'd1:    return m_dir[p];
            2'd2:    return m_pull[p];
            default: return m_mode[p];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_oe"},  pad_oe,  f_oe());
        check({req, " pad_out"}, pad_out, f_out());
        check({req, " pad_pu"},  pad_pu,  f_pu());
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (is_mapped(a)) begin
            case (a[4:3])
                2'd0: m_latch[a[2:0]] = d;
                2'd1: m_dir[a[2:0]]   = d;
                2'd2: m_pull[a[2:0]]  = d;
                default: m_mode[a[2:0]] = d;
            endcase
        end
    endtask

    task automatic do_read(input logic [7:0] a, input logic ps, output logic [7:0] q);
        @(negedge clk);
        addr = a; rd_pin = ps; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        m_pins = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] q;
        logic [7:0] hold;
        void'($urandom(32'd4051));
        for (int p = 0; p < 4; p++) begin
            m_latch[p] = '0; m_dir[p] = '0; m_pull[p] = '0; m_mode[p] = '0;
        end
        m_pins = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: everything clear after reset
        check("R2 oe", pad_oe, 32'h0);
        check("R2 pu", pad_pu, 32'h0);
        check("R2 out", pad_out, 32'h0);
        for (int p = 0; p < 4; p++) begin
            do_read(8'hC8 + 8'(p), 1'b0, q);
            check("R2 dir read", {24'h0, q}, 32'h0);
        end

        // R3: 0x55 at port 0 direction
        do_write(8'hC8, 8'h55);
        check("R3 even outputs", pad_oe, 32'h0000_0055);
        // R1/R4: push-pull latch drive
        do_write(8'hC0, 8'hFF);
        check("R4 pp out", pad_out, 32'h0000_00FF);
        check("R4 pp oe", pad_oe, 32'h0000_0055);
        do_read(8'hC0, 1'b0, q);
        check("R1 latch read", {24'h0, q}, 32'hFF);
        // R5: open drain
        do_write(8'hD8, 8'h0F);
        do_write(8'hC0, 8'h05);
        check_pads("R5 od");
        check("R5 oe value", pad_oe, 32'h0000_0050);
        // R6: pull-ups on inputs and released od pins
        do_write(8'hD0, 8'hFF);
        check("R6 pu value", pad_pu, 32'h0000_00AF);
        // R11: port 3 bit 7 is flat pin 31
        do_write(8'hCB, 8'h80);
        do_write(8'hC3, 8'h80);
        check("R11 pin31 oe", {31'h0, pad_oe[31]}, 32'h1);
        check("R11 pin31 out", {31'h0, pad_out[31]}, 32'h1);
        // R10: rd_pin ignored on non-data registers
        do_read(8'hC8, 1'b1, q);
        check("R10 dir w/ rd_pin", {24'h0, q}, 32'h55);
        do_read(8'hDB, 1'b1, q);
        check("R10 mode w/ rd_pin", {24'h0, q}, 32'h00);
        // R8: unmapped read and write
        do_read(8'hC4, 1'b0, q);
        check("R8 unmapped read C4", {24'h0, q}, 32'h0);
        do_read(8'hBF, 1'b1, q);
        check("R8 unmapped read BF", {24'h0, q}, 32'h0);
        do_write(8'hCC, 8'hFF);
        do_write(8'hE0, 8'hFF);
        check_pads("R8 unmapped write");
        // R9: rd_data holds without rd_en
        do_read(8'hC8, 1'b0, hold);
        do_write(8'hC8, 8'hAA);
        repeat (3) @(negedge clk);
        check("R9 hold", {24'h0, rd_data}, {24'h0, hold});

        // R7: synchronizer latency, pin change and read strobe in same cycle
        set_pins(32'h0000_3C00);
        @(negedge clk);
        pin_in = 32'h0000_C300;
        addr = 8'hC1; rd_pin = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        check("R7 edge1 old", {24'h0, rd_data}, 32'h3C);
        @(negedge clk);
        check("R7 edge2 old", {24'h0, rd_data}, 32'h3C);
        @(negedge clk);
        rd_en = 1'b0;
        check("R7 edge3 new", {24'h0, rd_data}, 32'hC3);
        m_pins = 32'h0000_C300;
        do_read(8'hC1, 1'b0, q);
        check("R7 latch vs pin", {24'h0, q}, {24'h0, m_latch[1]});

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            int op = int'($urandom % 8);
            logic [7:0] a;
            if ($urandom % 2 == 0)
                a = 8'hC0 + 8'(($urandom % 4) * 8) + 8'($urandom % 4);
            else
                a = 8'($urandom);
            if (op < 4) begin
                do_write(a, 8'($urandom));
                check_pads("R4/R5/R6 random write");
            end else if (op < 7) begin
                logic ps = 1'($urandom);
                do_read(a, ps, q);
                check("R1/R7/R8/R10 random read", {24'h0, q}, {24'h0, f_read(a, ps)});
            end else begin
                set_pins($urandom);
            end
        end
        finish_run();
    end
endmodule